// File: doc/BRIEF.md
# Dual-Port Serial Control Redirector

This block sits in front of a single 2-wire serial register-access slave. It decides which of two pin pairs reaches that slave: the dedicated primary clock/data pair, or a secondary pair that is available early in bring-up. It also decides which 7-bit slave address the slave answers to. The slave's open-drain data pull-down request is steered back only to the pin pair that currently owns the bus.

On every activation (reset release or an activation pulse) the two configuration-mode inputs are sampled. If both are low, the device is in development mode. The secondary pair is then routed to the slave with a fixed address. A register write can load a new primary-port address, and a second register write can hand control to the primary pair. A port change never happens in the middle of a serial transaction. It waits until the bus monitor sees the bus idle, meaning a STOP has followed the last START. Outside development mode the primary pair is always active, and every redirection or address write is discarded.

The slave's bit-level protocol is outside this block. The slave reports each register write as a strobe that carries the target field, the data, and a flag telling which pin pair carried the write.

Top module: `ctrl_port_redirect`

## Requirements
- R1: On activation, development mode is selected when conf_i equals 2'b00, and the secondary pair becomes active. The other three conf_i values select the primary pair.
- R2: The active pair's clock and data drive slv_scl_o and slv_sda_o. The pins of the inactive pair have no effect on them.
- R3: slv_sda_pull_i is forwarded only to the pull output of the active pair. The inactive pair's pull output stays 0, and also during reset.
- R4: While the secondary pair is active, slv_addr_o is 7'h34.
- R5: While the primary pair is active, slv_addr_o is the stored primary address. That address is 7'h1A in reset.
- R6: A write with wr_field_i=0 loads wr_data_i into the primary address only if the device is in development mode and wr_src_sec_i=1. Any other such write leaves the address unchanged.
- R7: A write with wr_field_i=1 requests the secondary pair when wr_data_i[0]=1 and the primary pair when wr_data_i[0]=0. It is honoured only in development mode. Outside development mode the primary pair stays active.
- R8: After a START (data falling while clock high) on the active pair, a requested port change is held until a STOP (data rising while clock high). It then takes effect within a few cycles.
- R9: activate_i re-samples conf_i. It re-initialises the active pair per R1 and resets the primary address to 7'h1A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| activate_i | input | 1 | One-cycle pulse on OFF-to-active transition |
| conf_i | input | 2 | Static configuration-mode pins |
| pri_scl_i | input | 1 | Primary pair clock |
| pri_sda_i | input | 1 | Primary pair data in |
| pri_sda_pull_o | output | 1 | Primary pair data pull-down |
| sec_scl_i | input | 1 | Secondary pair clock |
| sec_sda_i | input | 1 | Secondary pair data in |
| sec_sda_pull_o | output | 1 | Secondary pair data pull-down |
| slv_scl_o | output | 1 | Clock to the slave |
| slv_sda_o | output | 1 | Data to the slave |
| slv_sda_pull_i | input | 1 | Slave's data pull-down request |
| wr_en_i | input | 1 | Register-write strobe from the slave |
| wr_field_i | input | 1 | 0 = primary address, 1 = port select |
| wr_src_sec_i | input | 1 | Write arrived on the secondary pair |
| wr_data_i | input | 7 | Write data |
| slv_addr_o | output | 7 | Address the slave answers to |

## Verification
The hardest case to reach is a port change requested while a transaction is open on the active pair. The stimulus drives a START on the secondary pins and then issues the port-select write. It confirms that the secondary pair and address 7'h34 are still in force, then closes the bus with a STOP and confirms the handover. A second hard case is rejection of a primary-port address write while in development mode, which needs development mode with the primary pair already active. The bench reaches it by first handing control over through the secondary pair.

// File: rtl/ctrl_redir_pkg.sv
package ctrl_redir_pkg;
  typedef enum logic {
    FLD_DEV_ADDR = 1'b0,
    FLD_PORT_SEL = 1'b1
  } wr_field_e;

  localparam int unsigned CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_DEV = '0;
endpackage

// File: rtl/redir_mode_decode.sv
module redir_mode_decode
  import ctrl_redir_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              activate_i,
  input  logic [CONF_W-1:0] conf_i,
  output logic              act_o,
  output logic              dev_next_o,
  output logic              dev_mode_o
);
  logic boot_q, dev_q;

  // first cycle after reset behaves as an activation
  assign act_o      = activate_i | boot_q;
  assign dev_next_o = (conf_i == CONF_DEV);
  assign dev_mode_o = dev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
      dev_q  <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      if (act_o) dev_q <= dev_next_o;
    end
  end
endmodule

// File: rtl/redir_bus_monitor.sv
module redir_bus_monitor #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic clr_i,
  output logic busy_o
);
  logic [SYNC_STAGES-1:0] scl_st, sda_st;
  logic scl_prev, sda_prev, busy_q;
  logic scl_now, sda_now, start_det, stop_det;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_st[i] <= 1'b1;
          sda_st[i] <= 1'b1;
        end else begin
          scl_st[i] <= scl_i;
          sda_st[i] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_st[i] <= 1'b1;
          sda_st[i] <= 1'b1;
        end else begin
          scl_st[i] <= scl_st[i-1];
          sda_st[i] <= sda_st[i-1];
        end
      end
    end
  end

  assign scl_now   = scl_st[SYNC_STAGES-1];
  assign sda_now   = sda_st[SYNC_STAGES-1];
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
      busy_q   <= 1'b0;
    end else begin
      scl_prev <= scl_now;
      sda_prev <= sda_now;
      if (clr_i || stop_det) busy_q <= 1'b0;
      else if (start_det)    busy_q <= 1'b1;
    end
  end

  p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !clr_i) |=> busy_o);
endmodule

// File: rtl/redir_port_ctrl.sv
module redir_port_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic boot_dev_i,
  input  logic dev_mode_i,
  input  logic sel_we_i,
  input  logic sel_sec_i,
  input  logic busy_i,
  output logic sec_act_o,
  output logic switch_o
);
  logic req_q, sec_q;

  assign switch_o  = !act_i && !busy_i && (req_q != sec_q);
  assign sec_act_o = sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      sec_q <= 1'b0;
    end else if (act_i) begin
      req_q <= boot_dev_i;
      sec_q <= boot_dev_i;
    end else begin
      if (sel_we_i && dev_mode_i) req_q <= sel_sec_i;
      if (switch_o)               sec_q <= req_q;
    end
  end

  p_switch_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sec_q != $past(sec_q)) && !$past(act_i)) |-> !$past(busy_i));

  p_nondev_primary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_mode_i |-> !sec_q);
endmodule

// File: rtl/redir_addr_reg.sv
module redir_addr_reg #(
  parameter int unsigned     ADDR_W = 7,
  parameter logic [ADDR_W-1:0] RST_ADDR = 7'h1A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              dev_mode_i,
  input  logic              we_i,
  input  logic              src_sec_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic accept;

  assign accept = we_i && dev_mode_i && src_sec_i;
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= RST_ADDR;
    else if (act_i)  addr_q <= RST_ADDR;
    else if (accept) addr_q <= data_i;
  end

  p_addr_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept && !act_i) |=> $stable(addr_q));
endmodule

// File: rtl/ctrl_port_redirect.sv
module ctrl_port_redirect
  import ctrl_redir_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] SEC_ADDR    = 7'h34,
  parameter logic [ADDR_W-1:0] PRI_RST     = 7'h1A,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              activate_i,
  input  logic [1:0]        conf_i,
  input  logic              pri_scl_i,
  input  logic              pri_sda_i,
  output logic              pri_sda_pull_o,
  input  logic              sec_scl_i,
  input  logic              sec_sda_i,
  output logic              sec_sda_pull_o,
  output logic              slv_scl_o,
  output logic              slv_sda_o,
  input  logic              slv_sda_pull_i,
  input  logic              wr_en_i,
  input  logic              wr_field_i,
  input  logic              wr_src_sec_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] slv_addr_o
);
  logic act, dev_next, dev_mode, busy, sec_act, do_switch;
  logic addr_we, sel_we;
  logic [ADDR_W-1:0] pri_addr;
  wr_field_e fld;

  assign fld     = wr_field_e'(wr_field_i);
  assign addr_we = wr_en_i && (fld == FLD_DEV_ADDR);
  assign sel_we  = wr_en_i && (fld == FLD_PORT_SEL);

  redir_mode_decode i_mode (
    .clk_i, .rst_ni, .activate_i, .conf_i,
    .act_o(act), .dev_next_o(dev_next), .dev_mode_o(dev_mode)
  );

  redir_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) i_mon (
    .clk_i, .rst_ni,
    .scl_i(slv_scl_o), .sda_i(slv_sda_o),
    .clr_i(do_switch | act), .busy_o(busy)
  );

  redir_port_ctrl i_port (
    .clk_i, .rst_ni, .act_i(act), .boot_dev_i(dev_next), .dev_mode_i(dev_mode),
    .sel_we_i(sel_we), .sel_sec_i(wr_data_i[0]), .busy_i(busy),
    .sec_act_o(sec_act), .switch_o(do_switch)
  );

  redir_addr_reg #(.ADDR_W(ADDR_W), .RST_ADDR(PRI_RST)) i_addr (
    .clk_i, .rst_ni, .act_i(act), .dev_mode_i(dev_mode), .we_i(addr_we),
    .src_sec_i(wr_src_sec_i), .data_i(wr_data_i), .addr_o(pri_addr)
  );

  always_comb begin
    if (sec_act) begin
      slv_scl_o      = sec_scl_i;
      slv_sda_o      = sec_sda_i;
      sec_sda_pull_o = slv_sda_pull_i;
      pri_sda_pull_o = 1'b0;
      slv_addr_o     = SEC_ADDR;
    end else begin
      slv_scl_o      = pri_scl_i;
      slv_sda_o      = pri_sda_i;
      pri_sda_pull_o = slv_sda_pull_i;
      sec_sda_pull_o = 1'b0;
      slv_addr_o     = pri_addr;
    end
  end

  p_pull_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pri_sda_pull_o, sec_sda_pull_o}));

  p_activate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |=> (slv_addr_o == (($past(conf_i) == CONF_DEV) ? SEC_ADDR : PRI_RST)));
endmodule

// File: tb/test_ctrl_port_redirect.sv
`timescale 1ns/1ps
module test_ctrl_port_redirect;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, activate_i, pri_scl_i, pri_sda_i, sec_scl_i, sec_sda_i;
  logic slv_sda_pull_i, wr_en_i, wr_field_i, wr_src_sec_i;
  logic [1:0] conf_i;
  logic [6:0] wr_data_i, slv_addr_o;
  logic pri_sda_pull_o, sec_sda_pull_o, slv_scl_o, slv_sda_o;

  ctrl_port_redirect i_ctrl_port_redirect (
    .clk_i(clk), .rst_ni, .activate_i, .conf_i,
    .pri_scl_i, .pri_sda_i, .pri_sda_pull_o,
    .sec_scl_i, .sec_sda_i, .sec_sda_pull_o,
    .slv_scl_o, .slv_sda_o, .slv_sda_pull_i,
    .wr_en_i, .wr_field_i, .wr_src_sec_i, .wr_data_i, .slv_addr_o
  );

  typedef struct {
    string      rid;
    logic [6:0] addr;
    logic       sec;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int pushed = 0, served = 0;
  int checks = 0, errs = 0;
  bit done = 0;

  task automatic chk(input string rid, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", rid, what, act, exp);
    end
  endtask

  // monitor: pops expected state, samples away from the edge
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      cur = exp_q.pop_front();
      @(negedge clk);
      #1;
      chk(cur.rid, "slv_addr_o", {1'b0, slv_addr_o}, {1'b0, cur.addr});
      // primary clock held 0, secondary 1: output reveals the active pair
      chk(cur.rid, "active pair", {7'd0, slv_scl_o}, {7'd0, cur.sec});
      served++;
    end
  end

  task automatic expect_state(input string rid, input logic [6:0] a, input logic s);
    exp_t e;
    pri_scl_i = 1'b0;
    sec_scl_i = 1'b1;
    e.rid = rid; e.addr = a; e.sec = s;
    exp_q.push_back(e);
    pushed++;
    wait (served == pushed);
    @(negedge clk);
    pri_scl_i = 1'b1;
    sec_scl_i = 1'b1;
  endtask

  task automatic wr(input logic fld, input logic src, input logic [6:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_field_i = fld; wr_src_sec_i = src; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic activate(input logic [1:0] c);
    @(negedge clk);
    conf_i = c;
    activate_i = 1'b1;
    @(negedge clk);
    activate_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    rst_ni = 1'b0; activate_i = 1'b0; conf_i = 2'b00;
    pri_scl_i = 1'b1; pri_sda_i = 1'b1; sec_scl_i = 1'b1; sec_sda_i = 1'b1;
    slv_sda_pull_i = 1'b0; wr_en_i = 1'b0; wr_field_i = 1'b0;
    wr_src_sec_i = 1'b0; wr_data_i = '0;
    repeat (2) @(negedge clk);

    // reset state
    expect_state("R5 reset", 7'h1A, 1'b0);
    slv_sda_pull_i = 1'b1; #1;
    chk("R3 reset", "sec pull", {7'd0, sec_sda_pull_o}, 8'd0);
    chk("R3 reset", "pri pull", {7'd0, pri_sda_pull_o}, 8'd1);
    slv_sda_pull_i = 1'b0;

    @(negedge clk); rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    expect_state("R1 R4 dev boot", 7'h34, 1'b1);

    // R2 secondary routing
    @(negedge clk); sec_scl_i = 1'b0; #1;
    sec_sda_i = 1'b0; pri_sda_i = 1'b1; #1;
    chk("R2", "sda from sec", {7'd0, slv_sda_o}, 8'd0);
    pri_sda_i = 1'b0; #1;
    chk("R2", "pri sda ignored", {7'd0, slv_sda_o}, 8'd0);
    sec_sda_i = 1'b1; pri_sda_i = 1'b1; #1;
    sec_scl_i = 1'b1;
    // R3 pull to secondary
    slv_sda_pull_i = 1'b1; #1;
    chk("R3", "sec pull", {7'd0, sec_sda_pull_o}, 8'd1);
    chk("R3", "pri pull", {7'd0, pri_sda_pull_o}, 8'd0);
    slv_sda_pull_i = 1'b0;

    // R6 accepted via secondary, then R7 hand over to primary
    wr(1'b0, 1'b1, 7'h55);
    expect_state("R4 addr fixed", 7'h34, 1'b1);
    wr(1'b1, 1'b1, 7'h00);
    expect_state("R7 R6 to primary", 7'h55, 1'b0);
    wr(1'b0, 1'b0, 7'h2B);
    expect_state("R6 pri write rejected", 7'h55, 1'b0);

    slv_sda_pull_i = 1'b1; #1;
    chk("R3 primary", "pri pull", {7'd0, pri_sda_pull_o}, 8'd1);
    chk("R3 primary", "sec pull", {7'd0, sec_sda_pull_o}, 8'd0);
    slv_sda_pull_i = 1'b0;

    // R2 primary routing
    @(negedge clk); pri_scl_i = 1'b0; sec_scl_i = 1'b1; #1;
    chk("R2 primary", "scl", {7'd0, slv_scl_o}, 8'd0);
    pri_sda_i = 1'b0; sec_sda_i = 1'b1; #1;
    chk("R2 primary", "sda", {7'd0, slv_sda_o}, 8'd0);
    pri_sda_i = 1'b1; #1; pri_scl_i = 1'b1;
    repeat (4) @(negedge clk);

    // R8 deferred switch: back to secondary, open a transaction, request primary
    wr(1'b1, 1'b1, 7'h01);
    expect_state("R7 back to sec", 7'h34, 1'b1);
    @(negedge clk); sec_sda_i = 1'b0;          // START
    repeat (6) @(negedge clk);
    wr(1'b1, 1'b1, 7'h00);
    repeat (6) @(negedge clk);
    expect_state("R8 held while busy", 7'h34, 1'b1);
    @(negedge clk); sec_scl_i = 1'b0;
    @(negedge clk); sec_scl_i = 1'b1;
    repeat (4) @(negedge clk);
    sec_sda_i = 1'b1;                          // STOP
    repeat (8) @(negedge clk);
    expect_state("R8 after STOP", 7'h55, 1'b0);

    // R9 re-activation, non-development
    activate(2'b01);
    expect_state("R9 R1 conf01", 7'h1A, 1'b0);
    wr(1'b1, 1'b1, 7'h01);
    expect_state("R7 sel ignored", 7'h1A, 1'b0);
    wr(1'b0, 1'b1, 7'h66);
    expect_state("R6 nondev rejected", 7'h1A, 1'b0);
    @(negedge clk); sec_scl_i = 1'b0; #1;
    chk("R2 sec ignored", "scl", {7'd0, slv_scl_o}, 8'd1);
    sec_scl_i = 1'b1;

    activate(2'b10);
    expect_state("R1 conf10", 7'h1A, 1'b0);
    activate(2'b11);
    expect_state("R1 conf11", 7'h1A, 1'b0);
    activate(2'b00);
    expect_state("R9 R1 conf00", 7'h34, 1'b1);

    done = 1;
    report();
  end
endmodule